// File: doc/BRIEF.md
# Bus-Mapped Eight-Line GPIO Port

This block gives a peripheral bus eight static I/O lines. Software sets each line as a driven output or a released input through a direction register and supplies driven levels through an output data register. It samples the pin levels through an input register. Each pin presents three signals to a pad wrapper: the driven level, a driver-off control and the level sampled back from the pad. The pad levels pass through a two-stage synchroniser before any read can see them.

An access is one clock cycle with the active-low chip select low. The register is picked by address bits 3 and 2. The response (read data and error flag) appears in the cycle after the access. A three-state response machine records the outcome of the previous cycle. S_IDLE means no access took place. S_DONE means a legal access completed. S_FAULT means an illegal access was refused. On every clock the machine moves to S_DONE after a legal access, to S_FAULT after an illegal one, and to S_IDLE after a cycle with no access or a stalled access. Each of the three states can reach any of the three. When the sleep clock enable is low the register file is frozen and any selected access is held off with the wait signal.

Top module: `gpio_port`

## Requirements
- R1: After reset, pin_out and pin_tri are all 0 (every line an output driving 0), and bus_err, bus_rdata and bus_wait are 0.
- R2: The direction register is at address bits [3:2] = 10. It can be written and read back. Bit n = 1 sets pin_tri[n] = 1, which releases the driver of line n (input). Bit n = 0 makes the line an output. The change shows on pin_tri in the cycle after the write.
- R3: The output data register is at address 01 and is write-only. A write changes pin_out in the cycle after the access.
- R4: A read of address 00 returns the synchronised pin levels. A read whose access is sampled at clock edge P returns the pin_in value present at edge P-2.
- R5: A write to the input register (address 00) gives bus_err = 1 in the response cycle and changes no register.
- R6: A read of the output data register (address 01) gives bus_err = 1 in the response cycle and returns 0 data.
- R7: Any access to address 11 gives bus_err = 1 and changes no register.
- R8: With bus_cs_n high, the write, address and data inputs have no effect.
- R9: While sleep_en is low, bus_wait equals 1 whenever bus_cs_n is low. No write takes effect and no response (data or error) is produced.
- R10: bus_err is high only in the single cycle after an illegal access. It is 0 after an idle cycle.
- R11: bus_rdata is 0 in every cycle that is not the response to a legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Sleep clock enable; low freezes the registers |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr_hi | input | 2 | Address bits 3:2 selecting the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the response cycle |
| bus_err | output | 1 | Error response for an illegal access |
| bus_wait | output | 1 | Access held off while asleep |
| pin_in | input | 8 | Levels sampled from the pads |
| pin_out | output | 8 | Levels driven to the pads |
| pin_tri | output | 8 | Per-line driver off (1 = input) |

## Verification
A wrong response state shows at the ports in the very next cycle: the error flag or read data appears after the wrong access or fails to clear after an idle cycle. A corrupted output or direction register shows on pin_out or pin_tri one cycle after the offending access and stays there. A corrupted direction register also appears in every later direction read. A synchroniser with the wrong depth is exposed by back-to-back input reads straddling a pin change: the new level turns up one read early or late.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_IN  = 2'b00,
        SEL_OUT = 2'b01,
        SEL_DIR = 2'b10,
        SEL_RSV = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_DONE  = 2'b01,
        S_FAULT = 2'b10
    } resp_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_en,
    input  logic        cs_n,
    input  logic        wr,
    input  reg_sel_e    sel,
    output resp_state_e state,
    output logic        we_out,
    output logic        we_dir,
    output logic        rd_in,
    output logic        rd_dir,
    output logic        err
);
    resp_state_e state_q, state_d;
    logic        active;
    logic        legal;

    assign active = !cs_n && clk_en;

    always_comb begin
        legal = 1'b0;
        unique case (sel)
            SEL_IN:  legal = !wr;
            SEL_OUT: legal = wr;
            SEL_DIR: legal = 1'b1;
            SEL_RSV: legal = 1'b0;
        endcase
    end

    always_comb begin
        if (!active)    state_d = S_IDLE;
        else if (legal) state_d = S_DONE;
        else            state_d = S_FAULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        we_out = active && legal && wr && (sel == SEL_OUT);
        we_dir = active && legal && wr && (sel == SEL_DIR);
        rd_in  = active && legal && !wr && (sel == SEL_IN);
        rd_dir = active && legal && !wr && (sel == SEL_DIR);
        err    = 1'b0;
        unique case (state_q)
            S_IDLE:  err = 1'b0;
            S_DONE:  err = 1'b0;
            S_FAULT: err = 1'b1;
            default: err = 1'b0;
        endcase
    end

    assign state = state_q;

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(!cs_n && clk_en));
    assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !clk_en) |=> (state_q == S_IDLE));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_out,
    input  logic             we_dir,
    input  logic             rd_in,
    input  logic             rd_dir,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] rdata_q
);
    localparam logic [WIDTH-1:0] DIR_RESET = '0;
    localparam logic [WIDTH-1:0] OUT_RESET = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= OUT_RESET;
            dir_q   <= DIR_RESET;
            rdata_q <= '0;
        end else begin
            if (we_out) out_q <= wdata;
            if (we_dir) dir_q <= wdata;
            if (rd_in)       rdata_q <= pins_sync;
            else if (rd_dir) rdata_q <= dir_q;
            else             rdata_q <= '0;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_en,
    input  logic             bus_cs_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr_hi,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             bus_err,
    output logic             bus_wait,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_tri
);
    reg_sel_e    sel;
    resp_state_e state;
    logic        we_out, we_dir, rd_in, rd_dir;
    logic [WIDTH-1:0] pins_sync;

    assign sel      = reg_sel_e'(bus_addr_hi);
    assign bus_wait = !bus_cs_n && !sleep_en;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pins_sync)
    );

    gpio_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clk_en(sleep_en), .cs_n(bus_cs_n),
        .wr(bus_wr), .sel(sel), .state(state), .we_out(we_out),
        .we_dir(we_dir), .rd_in(rd_in), .rd_dir(rd_dir), .err(bus_err)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_out(we_out), .we_dir(we_dir),
        .rd_in(rd_in), .rd_dir(rd_dir), .wdata(bus_wdata),
        .pins_sync(pins_sync), .out_q(pin_out), .dir_q(pin_tri),
        .rdata_q(bus_rdata)
    );

    assert_no_stray_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_cs_n && sleep_en && bus_wr && bus_addr_hi == 2'b01) |=> $stable(pin_out));
    assert_no_stray_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_cs_n && sleep_en && bus_wr && bus_addr_hi == 2'b10) |=> $stable(pin_tri));
    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_DONE) |-> (bus_rdata == '0));
    assert_fault_nodata_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_en = 1'b1;
    logic       bus_cs_n = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr_hi = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_err, bus_wait;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_tri;

    int checks = 0;
    int failures = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic       pend = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .bus_cs_n(bus_cs_n),
        .bus_wr(bus_wr), .bus_addr_hi(bus_addr_hi), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_wait(bus_wait),
        .pin_in(pin_in), .pin_out(pin_out), .pin_tri(pin_tri)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge with cs released.
    task automatic access(input logic wr, input logic [1:0] a, input logic [7:0] d,
                          input logic [7:0] exp_d, input logic exp_e, input string tag);
        bus_cs_n = 1'b0; bus_wr = wr; bus_addr_hi = a; bus_wdata = d;
        exp_q.push_back({exp_e, exp_d});
        tag_q.push_back(tag);
        @(negedge clk);
        bus_cs_n = 1'b1; bus_wr = 1'b0;
    endtask

    always @(posedge clk) pend <= !bus_cs_n && sleep_en && rst_n;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL monitor unexpected response");
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " data"}, {24'h0, bus_rdata}, {24'h0, e[7:0]});
                check({t, " err"}, {31'h0, bus_err}, {31'h0, e[8]});
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin_out", {24'h0, pin_out}, 32'h0);
        check("R1 pin_tri", {24'h0, pin_tri}, 32'h0);
        check("R1 err", {31'h0, bus_err}, 32'h0);
        check("R1 rdata", {24'h0, bus_rdata}, 32'h0);
        check("R1 wait", {31'h0, bus_wait}, 32'h0);

        access(1'b1, 2'b01, 8'hA5, 8'h00, 1'b0, "R3 write out");
        check("R3 pin_out", {24'h0, pin_out}, 32'hA5);
        access(1'b1, 2'b10, 8'h0F, 8'h00, 1'b0, "R2 write dir");
        check("R2 pin_tri", {24'h0, pin_tri}, 32'h0F);
        access(1'b0, 2'b10, 8'h00, 8'h0F, 1'b0, "R2 read dir");
        @(negedge clk);
        check("R11 rdata idle", {24'h0, bus_rdata}, 32'h0);
        check("R10 err idle", {31'h0, bus_err}, 32'h0);

        pin_in = 8'h3C;
        repeat (3) @(negedge clk);
        access(1'b0, 2'b00, 8'h00, 8'h3C, 1'b0, "R4 read in");
        pin_in = 8'hC3;
        access(1'b0, 2'b00, 8'h00, 8'h3C, 1'b0, "R4 lag edge P");
        access(1'b0, 2'b00, 8'h00, 8'h3C, 1'b0, "R4 lag edge P+1");
        access(1'b0, 2'b00, 8'h00, 8'hC3, 1'b0, "R4 lag edge P+2");

        access(1'b1, 2'b00, 8'h55, 8'h00, 1'b1, "R5 write input");
        @(negedge clk);
        check("R10 err one cycle", {31'h0, bus_err}, 32'h0);
        check("R5 pin_out kept", {24'h0, pin_out}, 32'hA5);
        check("R5 pin_tri kept", {24'h0, pin_tri}, 32'h0F);

        access(1'b0, 2'b01, 8'h00, 8'h00, 1'b1, "R6 read out");
        access(1'b1, 2'b11, 8'hFF, 8'h00, 1'b1, "R7 write reserved");
        access(1'b0, 2'b11, 8'h00, 8'h00, 1'b1, "R7 read reserved");
        access(1'b0, 2'b10, 8'h00, 8'h0F, 1'b0, "R7 dir kept");
        check("R7 pin_out kept", {24'h0, pin_out}, 32'hA5);

        bus_wr = 1'b1; bus_addr_hi = 2'b01; bus_wdata = 8'h00;
        repeat (2) @(negedge clk);
        bus_wr = 1'b0;
        check("R8 pin_out no cs", {24'h0, pin_out}, 32'hA5);
        check("R8 err no cs", {31'h0, bus_err}, 32'h0);

        sleep_en = 1'b0;
        check("R9 wait low no cs", {31'h0, bus_wait}, 32'h0);
        bus_cs_n = 1'b0; bus_wr = 1'b1; bus_addr_hi = 2'b10; bus_wdata = 8'hF0;
        #1;
        check("R9 wait high", {31'h0, bus_wait}, 32'h1);
        repeat (2) @(negedge clk);
        check("R9 dir frozen", {24'h0, pin_tri}, 32'h0F);
        check("R9 no err", {31'h0, bus_err}, 32'h0);
        check("R9 wait held", {31'h0, bus_wait}, 32'h1);
        bus_cs_n = 1'b1; bus_wr = 1'b0;
        sleep_en = 1'b1;
        @(negedge clk);
        check("R9 wait released", {31'h0, bus_wait}, 32'h0);

        access(1'b1, 2'b10, 8'hF0, 8'h00, 1'b0, "R2 rewrite dir");
        check("R2 pin_tri new", {24'h0, pin_tri}, 32'hF0);
        access(1'b1, 2'b01, 8'h3C, 8'h00, 1'b0, "R3 rewrite out");
        check("R3 pin_out new", {24'h0, pin_out}, 32'h3C);
        @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule